// File: doc/BRIEF.md
# Multichannel Service Request Aggregator

This block gathers event pulses from up to sixteen serial channels into five request bitmaps: line error, receive data, transmit space, modem change and command done. Bit n of each bitmap belongs to channel n. A host reaches the block over a small register bus. A read-and-clear strobe returns a bitmap and zeroes it in the same access, so a pending request is never lost. One doorbell line tells the host that new requests exist. The host quiets the doorbell with a clear write. After servicing, it re-arms the doorbell with an acknowledge write.

Each channel also has an eight-bit command register. The host writes a set of command bits into an idle register. An internal engine breaks the set into single operations. It hands them one at a time, with the channel number, to the channel logic over a valid/ready stream. When the last operation is accepted, the engine clears the register to zero, records a per-operation failure mask as the channel status, and raises that channel's bit in the command-done bitmap. While `exec_valid` is high and `exec_ready` is low, the operation code and the channel hold steady. Nothing is dropped when the channel logic stalls.

Register map, on `hst_addr`:
- 0 to 4: the five bitmaps, in the order error, receive, transmit, modem, command-done.
- 5: doorbell clear.
- 6: acknowledge.
- `01cccc`: command register of channel `cccc`.
- `10cccc`: status of channel `cccc`.

Top module: `svc_req_hub`

## Requirements
- R1: After reset every bitmap reads zero and `irq_o` is low. A pulse on bit n of `ev_err`, `ev_in`, `ev_out` or `ev_mdm` sets bit n of bitmap 0, 1, 2 or 3 at the next clock edge. Bitmaps are read combinationally at their address.
- R2: With `hst_rdclr` high at bitmap address a (0 to 4), `hst_rdata` shows the bitmap's value before the edge, and the bitmap becomes zero at that edge. An event arriving in that same cycle is kept in the cleared bitmap.
- R3: Without `hst_rdclr`, or with `hst_rdclr` at an address above 4, no bitmap changes.
- R4: While armed, any new request raises `irq_o` at the next edge. A new request is an event pulse or a command completion. `irq_o` stays high until a write with `hst_wdata[0]`=1 to address 5.
- R5: A doorbell clear write disarms the doorbell. Until a write with `hst_wdata[0]`=1 to address 6, new requests do not raise `irq_o`. That acknowledge raises `irq_o` at the next edge only if a request arrived while disarmed; bitmaps left nonzero from before do not count.
- R6: A write to a command register is taken only when the register is zero and the data is nonzero. The register reads back its current value.
- R7: Each set command bit becomes one operation on `exec_op`, carrying the bit index as its code. The order is: bit 7 (transmitter off), bit 5 (receiver off), bit 2 (flush input), bit 3 (flush output), bit 0 (configure channel and line), bit 1 (configure channel only), bit 4 (receiver on), bit 6 (transmitter on).
- R8: While `exec_valid` is high and `exec_ready` is low, `exec_valid`, `exec_op` and `exec_ch` hold.
- R9: At the edge where the last operation of a command is accepted, the engine does three things. It clears the command register. It sets the channel's bit in bitmap 4. It sets the channel status to the mask of operation bits whose handshake had `exec_err` high; the status is zero on success.
- R10: When the engine is idle and several command registers are nonzero, the lowest channel index is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| ev_err | input | NCH | line error pulses, one per channel |
| ev_in | input | NCH | receive data pulses |
| ev_out | input | NCH | transmit space pulses |
| ev_mdm | input | NCH | modem change pulses |
| hst_addr | input | 6 | host register address |
| hst_wr | input | 1 | host write strobe |
| hst_rdclr | input | 1 | host read-and-clear strobe |
| hst_wdata | input | 8 | host write data |
| hst_rdata | output | 16 | host read data, combinational from `hst_addr` |
| irq_o | output | 1 | doorbell interrupt |
| exec_valid | output | 1 | operation offered to channel logic |
| exec_ready | input | 1 | channel logic accepts operation |
| exec_ch | output | 4 | channel of the offered operation |
| exec_op | output | 3 | operation code (command bit index) |
| exec_err | input | 1 | accepted operation failed |

## Verification
The bitmaps and doorbell are driven with sparse random event pulses on all four sources, mixed with read-and-clear strobes at every address and random clear and acknowledge writes. This separates a correct swap-to-zero from a clear that loses a same-cycle event, or one that hits the wrong bitmap. Directed sequences of clear, event and acknowledge show whether the doorbell counts only requests that arrive while it is disarmed. Commands are issued as a full eight-bit set, as a sparse set with one failing operation, and as three queued channels under random back-pressure. These cases expose errors in operation order, in channel priority, in the held operation during stalls, in the status mask, and in ignored writes to busy or zero commands.

// File: rtl/svc_pkg.sv
package svc_pkg;
  localparam int MAXCH = 16;
  localparam int CHB   = 4;
  localparam int NMAP  = 5;
  localparam int CMDW  = 8;
  localparam int OPW   = 3;
  localparam int RDW   = 16;
  localparam int AW    = 6;

  localparam logic [AW-1:0] A_DBCLR = 6'd5;
  localparam logic [AW-1:0] A_GACK  = 6'd6;
  localparam logic [1:0]    PG_CMD  = 2'b01;
  localparam logic [1:0]    PG_STS  = 2'b10;

  // execution rank -> command bit index
  function automatic logic [OPW-1:0] rank_op(input int unsigned r);
    case (r)
      0:       rank_op = 3'd7;
      1:       rank_op = 3'd5;
      2:       rank_op = 3'd2;
      3:       rank_op = 3'd3;
      4:       rank_op = 3'd0;
      5:       rank_op = 3'd1;
      6:       rank_op = 3'd4;
      default: rank_op = 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/svc_bitmap.sv
module svc_bitmap #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  // swap-to-zero: a set arriving with the clear survives
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= (clr_i ? '0 : q_o) | set_i;
  end
endmodule

// File: rtl/svc_doorbell.sv
module svc_doorbell (
  input  logic clk,
  input  logic rst_n,
  input  logic new_req_i,
  input  logic clr_wr_i,
  input  logic ack_wr_i,
  output logic irq_o,
  output logic armed_o
);
  logic late_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o   <= 1'b0;
      armed_o <= 1'b1;
      late_q  <= 1'b0;
    end else begin
      irq_o <= (irq_o & ~clr_wr_i) | (new_req_i & armed_o)
             | (ack_wr_i & (late_q | new_req_i));
      if (ack_wr_i)      armed_o <= 1'b1;
      else if (clr_wr_i) armed_o <= 1'b0;
      if (ack_wr_i)                     late_q <= 1'b0;
      else if (new_req_i && !armed_o)   late_q <= 1'b1;
    end
  end
endmodule

// File: rtl/svc_cmd_engine.sv
module svc_cmd_engine import svc_pkg::*; #(
  parameter int NCH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CHB-1:0]  wr_ch,
  input  logic [CMDW-1:0] wr_data,
  input  logic [CHB-1:0]  rd_ch,
  output logic [CMDW-1:0] rd_cmd,
  output logic [CMDW-1:0] rd_sts,
  output logic            exec_valid,
  input  logic            exec_ready,
  output logic [CHB-1:0]  exec_ch,
  output logic [OPW-1:0]  exec_op,
  input  logic            exec_err,
  output logic [NCH-1:0]  done_o
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [CMDW-1:0] cmd_r [NCH];
  logic [CMDW-1:0] sts_r [NCH];
  logic            busy_q;
  logic [CHB-1:0]  cur_q;
  logic [CMDW-1:0] work_q, err_q;
  logic [CHB-1:0]  pick;
  logic            found;
  logic [OPW-1:0]  op_sel;
  logic [CMDW-1:0] op_mask, work_rem, err_nx;
  logic            hs, last;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cmd_r[i] != '0) begin
        pick  = CHB'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    op_sel = '0;
    for (int r = CMDW - 1; r >= 0; r--) begin
      if (work_q[rank_op(r)]) op_sel = rank_op(r);
    end
  end

  assign op_mask  = CMDW'(1) << op_sel;
  assign hs       = busy_q && exec_ready;
  assign work_rem = work_q & ~op_mask;
  assign err_nx   = err_q | (exec_err ? op_mask : '0);
  assign last     = hs && (work_rem == '0);

  assign exec_valid = busy_q;
  assign exec_ch    = cur_q;
  assign exec_op    = op_sel;

  always_comb begin
    done_o = '0;
    if (last) done_o[cur_q[CHW-1:0]] = 1'b1;
  end

  assign rd_cmd = (int'(rd_ch) < NCH) ? cmd_r[rd_ch[CHW-1:0]] : '0;
  assign rd_sts = (int'(rd_ch) < NCH) ? sts_r[rd_ch[CHW-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      work_q <= '0;
      err_q  <= '0;
      for (int i = 0; i < NCH; i++) begin
        cmd_r[i] <= '0;
        sts_r[i] <= '0;
      end
    end else begin
      if (!busy_q && found) begin
        busy_q <= 1'b1;
        cur_q  <= pick;
        work_q <= cmd_r[pick[CHW-1:0]];
        err_q  <= '0;
      end
      if (hs) begin
        work_q <= work_rem;
        err_q  <= err_nx;
        if (last) begin
          busy_q                  <= 1'b0;
          cmd_r[cur_q[CHW-1:0]]   <= '0;
          sts_r[cur_q[CHW-1:0]]   <= err_nx;
        end
      end
      if (wr_en && int'(wr_ch) < NCH && wr_data != '0
          && cmd_r[wr_ch[CHW-1:0]] == '0)
        cmd_r[wr_ch[CHW-1:0]] <= wr_data;
    end
  end
endmodule

// File: rtl/svc_req_hub.sv
module svc_req_hub import svc_pkg::*; #(
  parameter int NCH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   ev_err,
  input  logic [NCH-1:0]   ev_in,
  input  logic [NCH-1:0]   ev_out,
  input  logic [NCH-1:0]   ev_mdm,
  input  logic [AW-1:0]    hst_addr,
  input  logic             hst_wr,
  input  logic             hst_rdclr,
  input  logic [CMDW-1:0]  hst_wdata,
  output logic [RDW-1:0]   hst_rdata,
  output logic             irq_o,
  output logic             exec_valid,
  input  logic             exec_ready,
  output logic [CHB-1:0]   exec_ch,
  output logic [OPW-1:0]   exec_op,
  input  logic             exec_err
);
  logic [NCH-1:0]  map_set [NMAP];
  logic [NCH-1:0]  map_q   [NMAP];
  logic [NMAP-1:0] map_clr;
  logic [NCH-1:0]  cmd_done;
  logic [NCH-1:0]  err_map, in_map, cmd_map;
  logic [CMDW-1:0] rd_cmd, rd_sts;
  logic            new_req, clr_wr, ack_wr, cmd_wr, armed;

  assign map_set[0] = ev_err;
  assign map_set[1] = ev_in;
  assign map_set[2] = ev_out;
  assign map_set[3] = ev_mdm;
  assign map_set[4] = cmd_done;

  generate
    for (genvar g = 0; g < NMAP; g++) begin : g_map
      assign map_clr[g] = hst_rdclr && (hst_addr == AW'(g));
      svc_bitmap #(.W(NCH)) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (map_set[g]),
        .clr_i (map_clr[g]),
        .q_o   (map_q[g])
      );
    end
  endgenerate

  assign err_map = map_q[0];
  assign in_map  = map_q[1];
  assign cmd_map = map_q[4];

  assign new_req = |{ev_err, ev_in, ev_out, ev_mdm, cmd_done};
  assign clr_wr  = hst_wr && hst_addr == A_DBCLR && hst_wdata[0];
  assign ack_wr  = hst_wr && hst_addr == A_GACK  && hst_wdata[0];
  assign cmd_wr  = hst_wr && hst_addr[AW-1:AW-2] == PG_CMD;

  svc_doorbell u_db (
    .clk       (clk),
    .rst_n     (rst_n),
    .new_req_i (new_req),
    .clr_wr_i  (clr_wr),
    .ack_wr_i  (ack_wr),
    .irq_o     (irq_o),
    .armed_o   (armed)
  );

  svc_cmd_engine #(.NCH(NCH)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cmd_wr),
    .wr_ch      (hst_addr[CHB-1:0]),
    .wr_data    (hst_wdata),
    .rd_ch      (hst_addr[CHB-1:0]),
    .rd_cmd     (rd_cmd),
    .rd_sts     (rd_sts),
    .exec_valid (exec_valid),
    .exec_ready (exec_ready),
    .exec_ch    (exec_ch),
    .exec_op    (exec_op),
    .exec_err   (exec_err),
    .done_o     (cmd_done)
  );

  always_comb begin
    hst_rdata = '0;
    case (hst_addr)
      6'd0: hst_rdata = RDW'(map_q[0]);
      6'd1: hst_rdata = RDW'(map_q[1]);
      6'd2: hst_rdata = RDW'(map_q[2]);
      6'd3: hst_rdata = RDW'(map_q[3]);
      6'd4: hst_rdata = RDW'(map_q[4]);
      default: begin
        if (hst_addr[AW-1:AW-2] == PG_CMD)      hst_rdata = RDW'(rd_cmd);
        else if (hst_addr[AW-1:AW-2] == PG_STS) hst_rdata = RDW'(rd_sts);
      end
    endcase
  end
endmodule

// File: rtl/svc_req_hub_chk.sv
module svc_req_hub_chk #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [5:0]     hst_addr,
  input logic           hst_wr,
  input logic           hst_rdclr,
  input logic           wd0,
  input logic [NCH-1:0] ev_err,
  input logic [NCH-1:0] ev_in,
  input logic [NCH-1:0] err_map,
  input logic [NCH-1:0] in_map,
  input logic [NCH-1:0] cmd_map,
  input logic           armed,
  input logic           irq_o,
  input logic           exec_valid,
  input logic           exec_ready,
  input logic [3:0]     exec_ch,
  input logic [2:0]     exec_op
);
  // R1
  ev_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_in != '0) |=> ((in_map & $past(ev_in)) == $past(ev_in)));

  // R2
  swap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rdclr && hst_addr == 6'd0) |=> (err_map == $past(ev_err)));

  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(hst_wr && hst_addr == 6'd5 && wd0)) |=> irq_o);

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !armed && !(hst_wr && hst_addr == 6'd6 && wd0)) |=> !irq_o);

  // R8
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && !exec_ready) |=>
      (exec_valid && $stable(exec_op) && $stable(exec_ch)));

  // R9
  done_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_map & ~$past(cmd_map)) != '0) |-> $past(exec_valid && exec_ready));
endmodule

bind svc_req_hub svc_req_hub_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hst_addr   (hst_addr),
  .hst_wr     (hst_wr),
  .hst_rdclr  (hst_rdclr),
  .wd0        (hst_wdata[0]),
  .ev_err     (ev_err),
  .ev_in      (ev_in),
  .err_map    (err_map),
  .in_map     (in_map),
  .cmd_map    (cmd_map),
  .armed      (armed),
  .irq_o      (irq_o),
  .exec_valid (exec_valid),
  .exec_ready (exec_ready),
  .exec_ch    (exec_ch),
  .exec_op    (exec_op)
);

// File: tb/tb_svc_req_hub.sv
module tb_svc_req_hub;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ev_err = '0, ev_in = '0, ev_out = '0, ev_mdm = '0;
  logic [5:0]  hst_addr = '0;
  logic        hst_wr = 1'b0, hst_rdclr = 1'b0;
  logic [7:0]  hst_wdata = '0;
  logic [15:0] hst_rdata;
  logic        irq_o, exec_valid, exec_err = 1'b0, exec_ready = 1'b0;
  logic [3:0]  exec_ch;
  logic [2:0]  exec_op;

  svc_req_hub #(.NCH(16)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_map [5];
  logic m_db = 1'b0, m_armed = 1'b1, m_late = 1'b0;
  int q[$];
  logic pv_stall = 1'b0;
  logic [2:0] pv_op = '0;
  logic [3:0] pv_ch = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int rank(input int r);
    int t[8] = '{7, 5, 2, 3, 0, 1, 4, 6};
    return t[r];
  endfunction

  // queue entry: ch<<8 | op<<4 | last<<1 | err
  task automatic expect_cmd(input int ch, input logic [7:0] d, input logic [7:0] em);
    int n = 0, k = 0;
    for (int r = 0; r < 8; r++) if (d[rank(r)]) n++;
    for (int r = 0; r < 8; r++) begin
      if (d[rank(r)]) begin
        k++;
        q.push_back((ch << 8) | (rank(r) << 4) | ((k == n) ? 2 : 0)
                    | (em[rank(r)] ? 1 : 0));
      end
    end
  endtask

  task automatic tick();
    logic [15:0] done_v = '0;
    logic [15:0] st [5];
    logic newr, clrw, ackw;
    int ent;
    exec_err = (q.size() > 0) ? q[0][0] : 1'b0;
    #1;
    if (pv_stall)
      chk(exec_valid && exec_op == pv_op && exec_ch == pv_ch, "R8", "stall hold",
          {exec_valid, exec_ch, exec_op}, {1'b1, pv_ch, pv_op});
    if (hst_addr < 6'd5)
      chk(hst_rdata == m_map[hst_addr], hst_rdclr ? "R2" : "R1", "bitmap read",
          hst_rdata, m_map[hst_addr]);
    if (exec_valid && exec_ready) begin
      if (q.size() == 0) chk(1'b0, "R7", "unexpected op", exec_op, 0);
      else begin
        ent = q.pop_front();
        // R7 order, R10 channel choice
        chk(exec_ch == 4'(ent >> 8) && exec_op == 3'((ent >> 4) & 7), "R7",
            "op/ch", {exec_ch, 1'b0, exec_op}, ((ent >> 8) << 4) | ((ent >> 4) & 7));
        if (ent & 2) done_v[ent >> 8] = 1'b1;
      end
    end
    pv_stall = exec_valid && !exec_ready;
    pv_op = exec_op;
    pv_ch = exec_ch;
    st[0] = ev_err; st[1] = ev_in; st[2] = ev_out; st[3] = ev_mdm; st[4] = done_v;
    newr = |{ev_err, ev_in, ev_out, ev_mdm, done_v};
    clrw = hst_wr && hst_addr == 6'd5 && hst_wdata[0];
    ackw = hst_wr && hst_addr == 6'd6 && hst_wdata[0];
    @(posedge clk);
    for (int i = 0; i < 5; i++)
      m_map[i] = ((hst_rdclr && hst_addr == 6'(i)) ? 16'h0 : m_map[i]) | st[i];
    m_db = (m_db & ~clrw) | (newr & m_armed) | (ackw & (m_late | newr));
    m_late = ackw ? 1'b0 : ((newr && !m_armed) ? 1'b1 : m_late);
    m_armed = ackw ? 1'b1 : (clrw ? 1'b0 : m_armed);
    @(negedge clk);
    chk(irq_o == m_db, "R4", "doorbell", irq_o, m_db);
  endtask

  task automatic idle_in();
    ev_err = '0; ev_in = '0; ev_out = '0; ev_mdm = '0;
    hst_wr = 1'b0; hst_rdclr = 1'b0; hst_wdata = '0;
  endtask

  task automatic hwrite(input logic [5:0] a, input logic [7:0] d);
    hst_addr = a; hst_wr = 1'b1; hst_wdata = d;
    tick();
    idle_in();
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [15:0] exp,
                        input string req, input string what);
    hst_addr = a;
    #1;
    chk(hst_rdata == exp, req, what, hst_rdata, exp);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && q.size() > 0; i++) begin
      exec_ready = ($urandom % 3) != 0;
      tick();
    end
    exec_ready = 1'b0;
    tick();
    chk(q.size() == 0, "R7", "ops left", q.size(), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R7 act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 5; i++) m_map[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(irq_o == 1'b0, "R1", "reset irq", irq_o, 0);
    chk(exec_valid == 1'b0, "R1", "reset valid", exec_valid, 0);
    for (int a = 0; a < 5; a++) rd_chk(6'(a), 16'h0, "R1", "reset bitmap");
    rd_chk(6'h13, 16'h0, "R6", "reset cmd");

    // random bitmap / doorbell traffic
    for (int c = 0; c < 1500; c++) begin
      idle_in();
      if ($urandom % 4 == 0) begin
        ev_err = 16'($urandom & $urandom & $urandom);
        ev_in  = 16'($urandom & $urandom & $urandom);
        ev_out = 16'($urandom & $urandom & $urandom);
        ev_mdm = 16'($urandom & $urandom & $urandom);
      end
      case ($urandom % 10)
        0, 1, 2, 3: begin hst_rdclr = 1'b1; hst_addr = 6'($urandom % 8); end
        4: begin hst_wr = 1'b1; hst_addr = 6'd5; hst_wdata = 8'(($urandom % 4) != 0); end
        5: begin hst_wr = 1'b1; hst_addr = 6'd6; hst_wdata = 8'(($urandom % 4) != 0); end
        default: hst_addr = 6'($urandom % 8);
      endcase
      tick();
    end
    idle_in();

    // R2 event in same cycle as read-and-clear
    ev_in = 16'h0001; hst_addr = 6'd1; tick(); idle_in();
    hst_rdclr = 1'b1; hst_addr = 6'd1; ev_in = 16'h0010; tick(); idle_in();
    rd_chk(6'd1, 16'h0010, "R2", "same-cycle event kept");

    // R3 clear strobe elsewhere leaves bitmap
    hst_rdclr = 1'b1; hst_addr = 6'd3; tick(); idle_in();
    ev_mdm = 16'h8001; tick(); idle_in();
    hst_rdclr = 1'b1; hst_addr = 6'd6; tick(); idle_in();
    hst_addr = 6'd3; tick();
    rd_chk(6'd3, 16'h8001, "R3", "no clear at addr 6");

    // R5 doorbell disarm / ack
    hwrite(6'd6, 8'h01);
    hwrite(6'd5, 8'h01);
    chk(irq_o == 1'b0, "R5", "after clear", irq_o, 0);
    ev_out = 16'h0004; tick(); idle_in();
    chk(irq_o == 1'b0, "R5", "disarmed event", irq_o, 0);
    hwrite(6'd6, 8'h01);
    chk(irq_o == 1'b1, "R5", "ack with late req", irq_o, 1);
    hwrite(6'd5, 8'h01);
    hwrite(6'd6, 8'h01);
    chk(irq_o == 1'b0, "R5", "ack without new req", irq_o, 0);
    ev_err = 16'h0100; tick(); idle_in();
    chk(irq_o == 1'b1, "R4", "armed event", irq_o, 1);

    // R7 R9 full command set, success
    hwrite(6'h13, 8'hFF);
    expect_cmd(3, 8'hFF, 8'h00);
    drain();
    rd_chk(6'h13, 16'h0, "R9", "cmd cleared");
    rd_chk(6'h23, 16'h0, "R9", "status zero");
    chk(m_map[4][3] == 1'b1, "R9", "done bit model", m_map[4], 16'h0008);
    rd_chk(6'd4, m_map[4], "R9", "done bitmap");

    // R9 failing op recorded in status
    hwrite(6'h19, 8'h25);
    expect_cmd(9, 8'h25, 8'h04);
    drain();
    rd_chk(6'h29, 16'h0004, "R9", "status mask");
    rd_chk(6'h19, 16'h0, "R9", "cmd cleared");

    // R10 priority, R6 busy write ignored
    exec_ready = 1'b0;
    hwrite(6'h17, 8'h10);
    tick();
    hwrite(6'h15, 8'h40);
    hwrite(6'h12, 8'h08);
    hwrite(6'h15, 8'h01);
    rd_chk(6'h15, 16'h0040, "R6", "busy reg unchanged");
    expect_cmd(7, 8'h10, 8'h00);
    expect_cmd(2, 8'h08, 8'h00);
    expect_cmd(5, 8'h40, 8'h00);
    drain();
    rd_chk(6'h15, 16'h0, "R10", "ch5 done");

    // R6 zero write ignored
    hwrite(6'h11, 8'h00);
    rd_chk(6'h11, 16'h0, "R6", "zero write");
    repeat (3) begin
      tick();
      chk(exec_valid == 1'b0, "R6", "no op for zero write", exec_valid, 0);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule